// File: doc/BRIEF.md
# Split 64-bit Register Access Bridge

This block lets a 32-bit register bus reach a small bank of 64-bit state: one configuration register, a set of general read/write registers and a set of free-running saturating event counters. Each 64-bit item is split across two consecutive 32-bit word addresses. Software writes the upper half first, which only loads a staging buffer. It then writes the lower half, and that write commits the whole 64-bit value in a single cycle.

Counters keep running between the two 32-bit reads that software needs to fetch them. Reading the upper half of a counter therefore also captures its lower half into a read latch, and the read of the lower half that follows returns the captured word. The two halves always come from the same cycle. The configuration register drives a one-cycle software-reset pulse and two watchdog control levels.

Top module: `split_reg_bridge`

## Requirements
- R1: `addr` is a 32-bit word index. Slot s holds bits 63..32 at word 2s and bits 31..0 at word 2s+1. With the default parameters, slot 0 is the configuration register, slots 1-2 are general registers, slots 3-4 are counters 0-1 and slots 5-7 are unmapped. A read requested with `rd_en` appears on `rd_data` after the next rising edge, and `rd_data` holds that value until the next read.
- R2: A write to an even (upper) word of a mapped slot loads only the shared 32-bit holding buffer. No 64-bit register or counter changes.
- R3: A write to an odd (lower) word of a mapped slot commits {holding buffer, write data} to that slot in the same edge. The holding buffer keeps its value after a commit, so a lower-only write reuses the last upper half held, which is zero after reset.
- R4: Reading the upper word of a counter also captures that counter's bits 31..0 into the shared read latch. Reading the lower word of any counter returns the latch. Reads of the configuration register and the general registers return live data and do not touch the latch.
- R5: Counter c increases by one on every edge where `cnt_inc[c]` is high. It stops at all-ones and does not wrap.
- R6: A commit to a counter replaces its value. An increment in the same cycle is dropped.
- R7: Committing the configuration register with bit 31 set makes `sw_reset_pulse` high for exactly the one cycle after that edge. Bit 31 is not stored and reads back as 0.
- R8: Configuration bit 30 drives `wdog_en` and bit 29 drives `wdog_force_fail` as levels, from the edge of the commit onward.
- R9: Unmapped words read as zero. Writes to them change nothing, not even the holding buffer.
- R10: Reset clears all registers, counters, the holding buffer, the read latch, `rd_data` and every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word index for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| cnt_inc | input | NUM_CNT | Per-counter increment request |
| sw_reset_pulse | output | 1 | One-cycle software reset request |
| wdog_en | output | 1 | Watchdog enable level |
| wdog_force_fail | output | 1 | Watchdog forced-failure level |

## Verification
A corrupted holding buffer does not show at the ports until the next lower-word commit. After that commit, the wrong upper half appears on the first read of the slot's upper word, so the bench commits and reads back in close succession. A stale or wrongly captured read latch shows one read later: the counter's lower word then disagrees with the pair a coherent snapshot predicts, and this is exposed by reading while the counter crosses a 32-bit carry. Saturation and commit priority errors show on the first readback after the stimulus, and the reset pulse and watchdog levels are compared after every single bus operation.

// File: rtl/srb_pkg.sv
`timescale 1ns/1ps
package srb_pkg;
  localparam int WORD_W = 32;
  localparam int REG_W  = 2 * WORD_W;

  // Saturating one-step increment of a 64-bit counter value.
  function automatic logic [REG_W-1:0] sat_step(input logic [REG_W-1:0] v);
    return (&v) ? v : v + REG_W'(1);
  endfunction

  // Join the staged upper half with the newly written lower half.
  function automatic logic [REG_W-1:0] join_words(input logic [WORD_W-1:0] hi,
                                                  input logic [WORD_W-1:0] lo);
    return {hi, lo};
  endfunction

  // Select one 32-bit half of a 64-bit value.
  function automatic logic [WORD_W-1:0] pick_word(input logic [REG_W-1:0] v,
                                                  input logic low);
    return low ? v[WORD_W-1:0] : v[REG_W-1:WORD_W];
  endfunction
endpackage

// File: rtl/srb_decode.sv
`timescale 1ns/1ps
module srb_decode #(
  parameter int ADDR_W    = 4,
  parameter int NUM_SLOTS = 5,
  parameter int CNT_BASE  = 3,
  localparam int SLOT_W   = ADDR_W - 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [SLOT_W-1:0] slot,
  output logic              low_half,
  output logic              mapped,
  output logic              is_cnt
);
  assign slot     = addr[ADDR_W-1:1];
  assign low_half = addr[0];
  assign mapped   = (32'(slot) < NUM_SLOTS);
  assign is_cnt   = mapped && (32'(slot) >= CNT_BASE);
endmodule

// File: rtl/srb_wstage.sv
`timescale 1ns/1ps
module srb_wstage
  import srb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              mapped,
  input  logic              low_half,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] hold_q,
  output logic              commit,
  output logic [REG_W-1:0]  commit_val
);
  logic stage_upper;

  assign stage_upper = wr_en && mapped && !low_half;
  assign commit      = wr_en && mapped && low_half;
  assign commit_val  = join_words(hold_q, wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           hold_q <= '0;
    else if (stage_upper) hold_q <= wdata;
  end

  AST_HOLD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mapped && !low_half) |=> (hold_q == $past(wdata)));  // R2
  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && mapped && !low_half) |=> $stable(hold_q));  // R9
endmodule

// File: rtl/srb_counter.sv
`timescale 1ns/1ps
module srb_counter
  import srb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             ld,
  input  logic [REG_W-1:0] ld_val,
  output logic [REG_W-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   value <= '0;
    else if (ld)  value <= ld_val;
    else if (inc) value <= sat_step(value);
  end

  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (value == $past(ld_val)));  // R6
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && (&value)) |=> (&value));  // R5
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !inc) |=> $stable(value));  // R5
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && inc && !(&value)) |=> (value != $past(value)));  // R5
endmodule

// File: rtl/split_reg_bridge.sv
`timescale 1ns/1ps
module split_reg_bridge
  import srb_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int NUM_RW  = 2,
  parameter int NUM_CNT = 2,
  localparam int SLOT_W    = ADDR_W - 1,
  localparam int CNT_BASE  = 1 + NUM_RW,
  localparam int NUM_SLOTS = CNT_BASE + NUM_CNT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic [31:0]        wr_data,
  input  logic               rd_en,
  output logic [31:0]        rd_data,
  input  logic [NUM_CNT-1:0] cnt_inc,
  output logic               sw_reset_pulse,
  output logic               wdog_en,
  output logic               wdog_force_fail
);
  localparam int RST_BIT = 31;
  localparam int WDE_BIT = 30;
  localparam int WDF_BIT = 29;

  logic [SLOT_W-1:0]            slot;
  logic                         low_half, mapped, is_cnt;
  logic [WORD_W-1:0]            hold_q;
  logic                         commit;
  logic [REG_W-1:0]             commit_val;
  logic [REG_W-1:0]             cfg_q;
  logic [NUM_RW-1:0][REG_W-1:0] rw_q;
  logic [REG_W-1:0]             cnt_val [NUM_CNT];
  logic [REG_W-1:0]             sel_val;
  logic [WORD_W-1:0]            rd_word;
  logic [WORD_W-1:0]            latch_q;
  logic                         cfg_commit;
  logic                         capture;

  srb_decode #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS), .CNT_BASE(CNT_BASE)) u_dec (
    .addr(addr), .slot(slot), .low_half(low_half), .mapped(mapped), .is_cnt(is_cnt)
  );

  srb_wstage u_wst (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .mapped(mapped), .low_half(low_half),
    .wdata(wr_data), .hold_q(hold_q), .commit(commit), .commit_val(commit_val)
  );

  assign cfg_commit = commit && (slot == '0);
  assign capture    = rd_en && is_cnt && !low_half;

  // Configuration register; the reset request bit is never stored.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q          <= '0;
      sw_reset_pulse <= 1'b0;
    end else begin
      sw_reset_pulse <= cfg_commit && commit_val[RST_BIT];
      if (cfg_commit) begin
        cfg_q          <= commit_val;
        cfg_q[RST_BIT] <= 1'b0;
      end
    end
  end

  assign wdog_en         = cfg_q[WDE_BIT];
  assign wdog_force_fail = cfg_q[WDF_BIT];

  // General registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rw_q <= '0;
    else begin
      for (int i = 0; i < NUM_RW; i++)
        if (commit && (32'(slot) == i + 1)) rw_q[i] <= commit_val;
    end
  end

  // Event counters.
  for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
    srb_counter u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(cnt_inc[c]),
      .ld(commit && (32'(slot) == CNT_BASE + c)),
      .ld_val(commit_val), .value(cnt_val[c])
    );
  end

  // Read selection.
  always_comb begin
    sel_val = '0;
    if (mapped) begin
      if (slot == '0) sel_val = cfg_q;
      for (int i = 0; i < NUM_RW; i++)
        if (32'(slot) == i + 1) sel_val = rw_q[i];
      for (int c = 0; c < NUM_CNT; c++)
        if (32'(slot) == CNT_BASE + c) sel_val = cnt_val[c];
    end
    rd_word = pick_word(sel_val, low_half);
    if (is_cnt && low_half) rd_word = latch_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      latch_q <= '0;
    end else if (rd_en) begin
      rd_data <= rd_word;
      if (capture) latch_q <= sel_val[WORD_W-1:0];
    end
  end

  AST_UPPER_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr[0]) |=> ($stable(cfg_q) && $stable(rw_q)));  // R2
  AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(1) && wr_data[RST_BIT]) |=> sw_reset_pulse);  // R7
  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset_pulse |-> $past(wr_en && addr == ADDR_W'(1)));  // R7
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !mapped) |=> (rd_data == '0));  // R9
  AST_LATCH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(latch_q));  // R4
endmodule

// File: tb/split_reg_bridge_tb.sv
`timescale 1ns/1ps
module split_reg_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [1:0]  cnt_inc = '0;
  logic        sw_reset_pulse, wdog_en, wdog_force_fail;

  int checks = 0;
  int failures = 0;

  logic [63:0] m_reg [5];
  logic [31:0] m_hold, m_latch;
  logic        m_pulse;

  always #4 clk = ~clk;

  split_reg_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .cnt_inc(cnt_inc),
    .sw_reset_pulse(sw_reset_pulse), .wdog_en(wdog_en), .wdog_force_fail(wdog_force_fail)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the operation.
  task automatic bus_op(input logic w, input logic r, input logic [3:0] a, input logic [31:0] d);
    wr_en = w; rd_en = r; addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr64(input logic [3:0] slot, input logic [63:0] v);
    bus_op(1'b1, 1'b0, {slot[2:0], 1'b0}, v[63:32]);
    bus_op(1'b1, 1'b0, {slot[2:0], 1'b1}, v[31:0]);
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    bus_op(1'b0, 1'b1, a, 32'h0);
    chk(req, rd_data, exp);
  endtask

  // Reference behaviour of one random operation, written from the requirements.
  task automatic model_op(input logic w, input logic [3:0] a, input logic [31:0] d,
                          output logic [31:0] exp_rd);
    int s;
    s = int'(a >> 1);
    exp_rd = 32'h0;
    m_pulse = 1'b0;
    if (w) begin
      if (s < 5) begin
        if (!a[0]) m_hold = d;
        else if (s == 0) begin
          m_reg[0] = {m_hold, d};
          m_reg[0][31] = 1'b0;
          m_pulse = d[31];
        end else m_reg[s] = {m_hold, d};
      end
    end else if (s < 5) begin
      if (a[0]) exp_rd = (s >= 3) ? m_latch : m_reg[s][31:0];
      else begin
        exp_rd = m_reg[s][63:32];
        if (s >= 3) m_latch = m_reg[s][31:0];
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] e;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 5; i++) m_reg[i] = '0;
    m_hold = '0; m_latch = '0; m_pulse = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk("R10 rd_data", rd_data, 32'h0);
    chk("R10 outputs", {29'h0, sw_reset_pulse, wdog_en, wdog_force_fail}, 32'h0);
    for (int a = 0; a < 16; a++) rd_chk("R10 reset read", 4'(a), 32'h0);

    // R3 lower-only write after reset uses zero upper half
    bus_op(1'b1, 1'b0, 4'd3, 32'hCAFE_0001);
    rd_chk("R3 zero-hold upper", 4'd2, 32'h0);
    rd_chk("R3 zero-hold lower", 4'd3, 32'hCAFE_0001);
    m_reg[1] = 64'h0000_0000_CAFE_0001;

    // R2 upper write alone does not change the register
    bus_op(1'b1, 1'b0, 4'd2, 32'h1111_2222);
    rd_chk("R2 staged not committed", 4'd2, 32'h0);
    // R9 unmapped write leaves the holding buffer alone
    bus_op(1'b1, 1'b0, 4'd12, 32'hDEAD_BEEF);
    bus_op(1'b1, 1'b0, 4'd13, 32'hDEAD_BEEF);
    rd_chk("R9 unmapped read", 4'd12, 32'h0);
    rd_chk("R9 unmapped read", 4'd13, 32'h0);
    bus_op(1'b1, 1'b0, 4'd3, 32'h3333_4444);
    rd_chk("R3 commit upper", 4'd2, 32'h1111_2222);
    rd_chk("R3 commit lower", 4'd3, 32'h3333_4444);
    // R3 hold persists after commit
    bus_op(1'b1, 1'b0, 4'd5, 32'h5555_6666);
    rd_chk("R3 hold reused", 4'd4, 32'h1111_2222);
    m_reg[1] = 64'h1111_2222_3333_4444;
    m_reg[2] = 64'h1111_2222_5555_6666;
    m_hold = 32'h1111_2222;

    // R7 R8 configuration register
    wr_en = 1'b1; addr = 4'd0; wr_data = 32'h0000_00AB;
    @(posedge clk); @(negedge clk);
    wr_data = 32'hE000_0000; addr = 4'd1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    chk("R7 pulse high", {31'h0, sw_reset_pulse}, 32'h1);
    chk("R8 wdog levels", {30'h0, wdog_en, wdog_force_fail}, 32'h3);
    @(negedge clk);
    chk("R7 pulse one cycle", {31'h0, sw_reset_pulse}, 32'h0);
    rd_chk("R7 bit31 not stored", 4'd1, 32'h6000_0000);
    rd_chk("R1 cfg upper", 4'd0, 32'h0000_00AB);
    m_reg[0] = 64'h0000_00AB_6000_0000;
    m_hold = 32'h0000_00AB;

    // Random mixed operations against the model (counters idle)
    for (int n = 0; n < 400; n++) begin
      logic        w;
      logic [3:0]  a;
      logic [31:0] d;
      w = $urandom_range(0, 1) == 1;
      a = 4'($urandom_range(0, 15));
      d = $urandom();
      if ($urandom_range(0, 3) == 0) d[31] = 1'b1;
      model_op(w, a, d, e);
      bus_op(w, !w, a, d);
      if (!w) chk("R1 R4 R9 random read", rd_data, e);
      chk("R7 random pulse", {31'h0, sw_reset_pulse}, {31'h0, m_pulse});
      chk("R8 random levels", {30'h0, wdog_en, wdog_force_fail}, {30'h0, m_reg[0][30], m_reg[0][29]});
    end

    // R4 coherent read across a 32-bit carry
    wr64(4'd3, 64'h0000_0000_FFFF_FFFF);
    cnt_inc = 2'b01;
    rd_chk("R4 coherent upper", 4'd6, 32'h0000_0000);
    rd_chk("R4 coherent lower", 4'd7, 32'hFFFF_FFFF);
    cnt_inc = 2'b00;
    rd_chk("R5 counted upper", 4'd6, 32'h0000_0001);
    rd_chk("R5 counted lower", 4'd7, 32'h0000_0001);
    // R4 general-register read does not disturb the latch
    rd_chk("R4 live general read", 4'd3, m_reg[1][31:0]);
    rd_chk("R4 latch kept", 4'd7, 32'h0000_0001);

    // R6 commit beats a same-cycle increment
    bus_op(1'b1, 1'b0, 4'd6, 32'h0000_0012);
    cnt_inc = 2'b01;
    bus_op(1'b1, 1'b0, 4'd7, 32'h0000_0034);
    cnt_inc = 2'b00;
    rd_chk("R6 load upper", 4'd6, 32'h0000_0012);
    rd_chk("R6 load lower", 4'd7, 32'h0000_0034);

    // R5 saturation at all-ones
    wr64(4'd4, 64'hFFFF_FFFF_FFFF_FFFE);
    cnt_inc = 2'b10;
    repeat (3) @(negedge clk);
    cnt_inc = 2'b00;
    rd_chk("R5 saturated upper", 4'd8, 32'hFFFF_FFFF);
    rd_chk("R5 saturated lower", 4'd9, 32'hFFFF_FFFF);
    // counter 0 untouched by counter 1 increments
    rd_chk("R5 other counter", 4'd6, 32'h0000_0012);
    rd_chk("R5 other counter", 4'd7, 32'h0000_0034);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule